// File: doc/BRIEF.md
# Flash Command Interface with Page-Mode Configuration

This block is the command front end of a parallel NOR flash model. It watches host write cycles (address, data word, write strobe) and decodes a small command set. One command is a two-write sequence that loads a volatile configuration register. The value for that register travels on the low 16 address bits, not on the data bus. Bit 13 of that register picks the page size used for asynchronous page reads: 4 words or 8 words.

Reads are served from a page buffer. In array-read mode, a read whose page is already buffered is answered from the buffer. A read to any other page reloads the whole page from a small computed array. In register-read mode, each read loads one word only: the configuration register. Any write cycle invalidates the buffer, so the first array read after any command always reloads. A sticky sequence-error flag records a set-configuration sequence that was not confirmed.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the interface is in array-read mode with 4-word pages. `seq_err` is 0 and `rvalid` and `page_load` are low.
- R2: A write of data 0x0060 followed by a write of data 0x0004 loads the configuration register from addr[15:0] of the 0x0060 cycle. `page8` then equals bit 13 of that value.
- R3: Only bit 13 of the configuration register is kept. All other bits read back as 0, even when 1s were presented on the address bus.
- R4: After the second cycle of the set-configuration sequence the interface is in array-read mode. This holds whether that cycle confirmed the sequence or aborted it.
- R5: If the write after 0x0060 carries any data other than 0x0004, the configuration register keeps its value and `seq_err` becomes 1.
- R6: A write of 0x0050 clears `seq_err` and leaves the configuration unchanged. This also holds when it is issued directly after a set-configuration sequence.
- R7: A write of 0x0090 enters register-read mode. A write of 0x00FF returns to array-read mode. Other command words are ignored.
- R8: An array read with `rd_en` returns word i = ((i * 0x0101) ^ 0x5A00) mod 2^16 on `rdata`, where i = addr[MEM_AW-1:0]. The data appears with `rvalid` one cycle after the strobe.
- R9: In 4-word mode a page is addr[MEM_AW-1:2]. A read to the buffered page does not pulse `page_load`. A read to another page pulses `page_load` and reloads the buffer.
- R10: In 8-word mode a page is addr[MEM_AW-1:3], so offsets 0 to 7 of one page are served without reload.
- R11: Any write cycle, and any register-mode read, invalidates the array page. The next array read then pulses `page_load`.
- R12: In register-read mode every read returns the configuration register and pulses `page_load`, because one word is loaded per read.
- R13: Reset returns the configuration register to 0x0000 (4-word pages) from any prior value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Bus address; also carries the configuration value |
| wdata | input | 16 | Write data (command word) |
| rdata | output | 16 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| page_load | output | 1 | The read just served loaded the buffer |
| page8 | output | 1 | 1 when 8-word pages are selected |
| reg_mode | output | 1 | 1 in register-read mode |
| seq_err | output | 1 | Sticky set-configuration sequence error |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that no read is issued between the two writes of a set-configuration sequence, and that both strobes are low while reset is held. The bench drives every bus operation as a single-cycle strobe from the falling edge, and it drops the strobe before the next operation, so these conditions hold throughout. Expected read words and page reloads come from the array formula and the page boundaries stated in the requirements.

// File: rtl/fci_pkg.sv
// Shared constants and types for the flash command interface.
// Assumes 16-bit command words and at most 8-word pages.
package fci_pkg;
    localparam int WORD_W   = 16;
    localparam int PAGE_MAX = 8;
    localparam int OFF_W    = $clog2(PAGE_MAX);
    localparam int PAGE8_BIT = 13;

    localparam logic [WORD_W-1:0] CMD_SET_CFG  = 16'h0060;
    localparam logic [WORD_W-1:0] CMD_CONFIRM  = 16'h0004;
    localparam logic [WORD_W-1:0] CMD_CLR_STAT = 16'h0050;
    localparam logic [WORD_W-1:0] CMD_RD_REG   = 16'h0090;
    localparam logic [WORD_W-1:0] CMD_RD_ARRAY = 16'h00FF;

    typedef enum logic {SEQ_IDLE, SEQ_WAIT_CONFIRM} seq_state_t;

    // Computed array contents: one word per index.
    function automatic logic [WORD_W-1:0] array_word(input logic [WORD_W-1:0] idx);
        return (idx * 16'h0101) ^ 16'h5A00;
    endfunction
endpackage

// File: rtl/fci_cmd_decoder.sv
// Command decoder: tracks read mode, the set-configuration sequence,
// the configuration register and the sticky sequence-error flag.
// Assumes one write per wr_en pulse and ADDR_W >= 16.
module fci_cmd_decoder
    import fci_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cfg_q,
    output logic              reg_mode,
    output logic              seq_err,
    output logic              seq_busy
);
    localparam logic [WORD_W-1:0] CFG_KEEP = WORD_W'(1) << PAGE8_BIT;

    seq_state_t        state_q;
    logic [WORD_W-1:0] pend_q;

    assign seq_busy = (state_q == SEQ_WAIT_CONFIRM);

    // Decode each write cycle and update mode, sequence and register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            pend_q   <= '0;
            cfg_q    <= '0;
            reg_mode <= 1'b0;
            seq_err  <= 1'b0;
        end else if (wr_en) begin
            if (state_q == SEQ_WAIT_CONFIRM) begin
                state_q  <= SEQ_IDLE;
                reg_mode <= 1'b0;
                if (wdata == CMD_CONFIRM) begin
                    cfg_q <= pend_q & CFG_KEEP;
                end else begin
                    seq_err <= 1'b1;
                end
            end else begin
                unique case (wdata)
                    CMD_SET_CFG: begin
                        state_q <= SEQ_WAIT_CONFIRM;
                        pend_q  <= addr[WORD_W-1:0];
                    end
                    CMD_RD_REG:   reg_mode <= 1'b1;
                    CMD_RD_ARRAY: reg_mode <= 1'b0;
                    CMD_CLR_STAT: seq_err  <= 1'b0;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fci_array_rom.sv
// Small computed array with NPORTS parallel combinational read ports,
// so a whole page can be fetched in one cycle.
module fci_array_rom
    import fci_pkg::*;
#(
    parameter int MEM_AW = 6,
    parameter int NPORTS = PAGE_MAX
) (
    input  logic [NPORTS-1:0][MEM_AW-1:0] rd_addr,
    output logic [NPORTS-1:0][WORD_W-1:0] rd_data
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        // Each port returns the computed word for its index.
        assign rd_data[p] = array_word(WORD_W'(rd_addr[p]));
    end
endmodule

// File: rtl/fci_page_buf.sv
// Page buffer: serves array reads from a buffered page or reloads it,
// and serves register reads as single-word loads.
// Assumes rd_en and wr_en are never high together; MEM_AW >= 3.
module fci_page_buf
    import fci_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic                            wr_en,
    input  logic                            reg_mode,
    input  logic                            page8,
    input  logic [MEM_AW-1:0]               addr,
    input  logic [WORD_W-1:0]               cfg_word,
    output logic [PAGE_MAX-1:0][MEM_AW-1:0] rom_addr,
    input  logic [PAGE_MAX-1:0][WORD_W-1:0] rom_data,
    output logic [WORD_W-1:0]               rdata,
    output logic                            rvalid,
    output logic                            page_load
);
    logic [WORD_W-1:0] buf_q [PAGE_MAX];
    logic [MEM_AW-1:0] tag_q;
    logic              tag8_q;
    logic              buf_valid;
    logic [MEM_AW-1:0] off_mask;
    logic [MEM_AW-1:0] base;
    logic [OFF_W-1:0]  off;
    logic              hit;

    // Derive the page base, the word offset and the hit decision.
    always_comb begin
        off_mask = page8 ? MEM_AW'(PAGE_MAX - 1) : MEM_AW'(PAGE_MAX / 2 - 1);
        base     = addr & ~off_mask;
        off      = addr[OFF_W-1:0] & off_mask[OFF_W-1:0];
        hit      = buf_valid && (base == tag_q) && (page8 == tag8_q);
    end

    for (genvar k = 0; k < PAGE_MAX; k++) begin : g_fetch
        assign rom_addr[k] = base | MEM_AW'(k);
    end

    // Serve reads, reload pages and invalidate on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < PAGE_MAX; k++) buf_q[k] <= '0;
            tag_q     <= '0;
            tag8_q    <= 1'b0;
            buf_valid <= 1'b0;
            rdata     <= '0;
            rvalid    <= 1'b0;
            page_load <= 1'b0;
        end else if (wr_en) begin
            buf_valid <= 1'b0;
            rvalid    <= 1'b0;
            page_load <= 1'b0;
        end else if (rd_en) begin
            rvalid <= 1'b1;
            if (reg_mode) begin
                rdata     <= cfg_word;
                page_load <= 1'b1;
                buf_valid <= 1'b0;
            end else if (hit) begin
                rdata     <= buf_q[off];
                page_load <= 1'b0;
            end else begin
                for (int k = 0; k < PAGE_MAX; k++) begin
                    if (page8 || k < PAGE_MAX / 2) buf_q[k] <= rom_data[k];
                end
                rdata     <= rom_data[off];
                tag_q     <= base;
                tag8_q    <= page8;
                buf_valid <= 1'b1;
                page_load <= 1'b1;
            end
        end else begin
            rvalid    <= 1'b0;
            page_load <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_cmd_if.sv
// Top of the flash command interface: command decoder, page buffer
// and computed array. Assumes single-cycle, non-overlapping strobes.
module flash_cmd_if
    import fci_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rvalid,
    output logic              page_load,
    output logic              page8,
    output logic              reg_mode,
    output logic              seq_err
);
    logic [WORD_W-1:0]               cfg_q;
    logic                            seq_busy;
    logic [PAGE_MAX-1:0][MEM_AW-1:0] rom_addr;
    logic [PAGE_MAX-1:0][WORD_W-1:0] rom_data;

    assign page8 = cfg_q[PAGE8_BIT];

    fci_cmd_decoder #(.ADDR_W(ADDR_W)) dec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cfg_q    (cfg_q),
        .reg_mode (reg_mode),
        .seq_err  (seq_err),
        .seq_busy (seq_busy)
    );

    fci_array_rom #(.MEM_AW(MEM_AW), .NPORTS(PAGE_MAX)) rom_i (
        .rd_addr (rom_addr),
        .rd_data (rom_data)
    );

    fci_page_buf #(.MEM_AW(MEM_AW)) pbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .reg_mode  (reg_mode),
        .page8     (page8),
        .addr      (addr[MEM_AW-1:0]),
        .cfg_word  (cfg_q),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .page_load (page_load)
    );
endmodule

// File: rtl/fci_cmd_chk.sv
// Checker for the flash command interface, bound to the top module.
module fci_cmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        rvalid,
    input logic        page_load,
    input logic        page8,
    input logic        reg_mode,
    input logic        seq_err,
    input logic        seq_busy
);
    // R8
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en));

    // R5
    abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seq_busy && wdata != 16'h0004) |=> seq_err);

    // R4
    seq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seq_busy) |=> (!seq_busy && !reg_mode));

    // R2
    page8_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(page8));

    // R3
    reg_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && reg_mode) |-> ((rdata & 16'hDFFF) == 16'h0000));

    // R11
    load_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && rd_en) |=> page_load);

    // R9
    load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_load |-> rvalid);
endmodule

bind flash_cmd_if fci_cmd_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .page_load (page_load),
    .page8     (page8),
    .reg_mode  (reg_mode),
    .seq_err   (seq_err),
    .seq_busy  (seq_busy)
);

// File: tb/flash_cmd_if_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid, page_load, page8, reg_mode, seq_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_if #(.ADDR_W(16), .MEM_AW(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .page_load(page_load), .page8(page8), .reg_mode(reg_mode),
        .seq_err(seq_err)
    );

    typedef struct packed {
        logic        is_wr;
        logic [15:0] a;
        logic [15:0] d;
        logic        exp_load;
        logic        exp_p8;
    } vec_t;

    // Walked after reset: R8 R9 R10 R11 R2 R6
    localparam vec_t VECS [14] = '{
        '{1'b0, 16'h0005, 16'h0000, 1'b1, 1'b0}, // R9 first read loads
        '{1'b0, 16'h0006, 16'h0000, 1'b0, 1'b0}, // R9 same 4-word page
        '{1'b0, 16'h0007, 16'h0000, 1'b0, 1'b0},
        '{1'b0, 16'h0004, 16'h0000, 1'b0, 1'b0},
        '{1'b0, 16'h0008, 16'h0000, 1'b1, 1'b0}, // R9 new page
        '{1'b0, 16'h000B, 16'h0000, 1'b0, 1'b0},
        '{1'b1, 16'h2000, 16'h0060, 1'b0, 1'b0}, // R2 first cycle
        '{1'b1, 16'h2000, 16'h0004, 1'b0, 1'b1}, // R2 confirm
        '{1'b0, 16'h0008, 16'h0000, 1'b1, 1'b1}, // R11 reload after write
        '{1'b0, 16'h000F, 16'h0000, 1'b0, 1'b1}, // R10 8-word page
        '{1'b0, 16'h000C, 16'h0000, 1'b0, 1'b1}, // R10
        '{1'b0, 16'h0010, 16'h0000, 1'b1, 1'b1}, // R10 next page
        '{1'b1, 16'h0000, 16'h0050, 1'b0, 1'b1}, // R6 third cycle
        '{1'b0, 16'h0017, 16'h0000, 1'b1, 1'b1}  // R11
    };

    function automatic logic [15:0] exp_word(input logic [15:0] a);
        logic [15:0] i;
        i = {10'd0, a[5:0]};
        return (i * 16'h0101) ^ 16'h5A00;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [15:0] exp_d,
                          input logic exp_ld, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(rvalid == 1'b1, req, 32'(rvalid), 32'd1);
        check(rdata == exp_d, req, 32'(rdata), 32'(exp_d));
        check(page_load == exp_ld, req, 32'(page_load), 32'(exp_ld));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired, got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(page8 == 1'b0, "R1", 32'(page8), 32'd0);
        check(reg_mode == 1'b0, "R1", 32'(reg_mode), 32'd0);
        check(seq_err == 1'b0, "R1", 32'(seq_err), 32'd0);
        check(rvalid == 1'b0 && page_load == 1'b0, "R1", 32'({rvalid, page_load}), 32'd0);

        for (int v = 0; v < 14; v++) begin
            if (VECS[v].is_wr) begin
                bus_wr(VECS[v].a, VECS[v].d);
                check(page8 == VECS[v].exp_p8, "R2 R6 table", 32'(page8), 32'(VECS[v].exp_p8));
            end else begin
                bus_rd(VECS[v].a, exp_word(VECS[v].a), VECS[v].exp_load, "R8 R9 R10 R11 table");
            end
        end

        // R3 reserved bits dropped; R12 register reads
        bus_wr(16'hFFFF, 16'h0060);
        bus_wr(16'hFFFF, 16'h0004);
        check(page8 == 1'b1, "R3", 32'(page8), 32'd1);
        bus_wr(16'h0000, 16'h0090);
        check(reg_mode == 1'b1, "R7", 32'(reg_mode), 32'd1);
        bus_rd(16'h0003, 16'h2000, 1'b1, "R3 R12");
        bus_rd(16'h0003, 16'h2000, 1'b1, "R12");
        // R7 unknown command ignored, R7 back to array
        bus_wr(16'h0000, 16'h0033);
        check(reg_mode == 1'b1 && page8 == 1'b1, "R7", 32'({reg_mode, page8}), 32'd3);
        bus_wr(16'h0000, 16'h00FF);
        check(reg_mode == 1'b0, "R7", 32'(reg_mode), 32'd0);
        bus_rd(16'h0011, exp_word(16'h0011), 1'b1, "R11");
        bus_rd(16'h0012, exp_word(16'h0012), 1'b0, "R10");

        // R4 R5 abort keeps configuration
        bus_wr(16'h0090, 16'h0090);
        bus_wr(16'h0000, 16'h0060);
        bus_wr(16'h0000, 16'h0041);
        check(seq_err == 1'b1, "R5", 32'(seq_err), 32'd1);
        check(page8 == 1'b1, "R5", 32'(page8), 32'd1);
        check(reg_mode == 1'b0, "R4", 32'(reg_mode), 32'd0);
        bus_wr(16'h0000, 16'h0050);
        check(seq_err == 1'b0, "R6", 32'(seq_err), 32'd0);
        check(page8 == 1'b1, "R6", 32'(page8), 32'd1);

        // R6 clear-status right after sequence; back to 4-word pages
        bus_wr(16'h0000, 16'h0060);
        bus_wr(16'h0000, 16'h0004);
        bus_wr(16'h0000, 16'h0050);
        check(page8 == 1'b0 && seq_err == 1'b0, "R6", 32'({page8, seq_err}), 32'd0);
        bus_rd(16'h0005, exp_word(16'h0005), 1'b1, "R9");
        bus_rd(16'h0007, exp_word(16'h0007), 1'b0, "R9");
        bus_rd(16'h0003, exp_word(16'h0003), 1'b1, "R9");

        // R13 reset restores defaults
        bus_wr(16'h2000, 16'h0060);
        bus_wr(16'h2000, 16'h0004);
        bus_wr(16'h0000, 16'h0090);
        check(page8 == 1'b1, "R13", 32'(page8), 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(page8 == 1'b0, "R13", 32'(page8), 32'd0);
        check(reg_mode == 1'b0, "R13", 32'(reg_mode), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule